// File: doc/BRIEF.md
# Camera Capture Status Event Register

This block gathers the event pulses and level conditions of a camera capture interface into a single read-only 32-bit status word. The capture datapath sends it one-cycle pulses for these events: frame sync, a FIFO write attempted while that FIFO is full, an uncorrected sync-code CRC failure, completion of each DMA channel, and completion of a reset or disable request. Each event is caught in a sticky flag. The flag stays set until software reads the word through a one-cycle read strobe at the status offset, and that read clears it.

Three bits are live levels that reading does not change: module enabled, channel-handoff busy, and codec request pending. After a DMA channel status change is accepted, the block holds a busy window of a fixed length. Further change requests are refused during that window. A codec request that cannot be served in the current frame is held as pending until the next frame sync, and the block issues it then. The block also reports two conditions combinationally. The frame is skipped when a frame sync arrives while the FIFOs are flushing. The frame is dropped when a CRC failure counts because correction is enabled.

Top module: `cam_status_reg`

## Requirements
- R1: After reset, every flag and level the block holds is 0, and a status read (`rd_strobe`=1, `rd_addr`=0x28) returns 0x00000000 while `mod_enable` is 0.
- R2: A sticky flag stays at 1 from the clock edge after its event until a status read at offset 0x28. After that read it is 0, unless a new event arrives.
- R3: Bit 27 (frame overrun) is set only by `ev_vsync` while `fifo_flushing` is 1. `frame_skip` is 1 in exactly those cycles.
- R4: Bit 26 (sync CRC error) is set only by `crc_err` while `crc_fix_en` is 1. `frame_drop` is 1 in exactly those cycles.
- R5: Bit 24 is set by `prv_wr` while `prv_full` is 1. Bit 25 is set by `cdc_wr` while `cdc_full` is 1. A write to a FIFO that is not full sets neither bit, and each path sets only its own bit.
- R6: `ev_vsync` sets bit 10, `prv_done` sets bit 16, `cdc_done` sets bit 17, `srst_done` sets bit 2 and `dis_done` sets bit 1, each as a sticky flag.
- R7: Bit 0 follows `mod_enable`, bit 19 shows the handoff-busy level and bit 8 shows codec pending. A status read does not clear any of these bits.
- R8: `chan_ack` equals `chan_req` when no handoff is busy. An accepted request makes bit 19 read 1 for the next SYNC_CYC cycles (default 4), and `chan_ack` is 0 during those cycles.
- R9: `codec_req` with `codec_fits`=0 sets codec pending from the next cycle. `ev_vsync` clears it, and in that same cycle `codec_go` pulses. A new deferred request in the cycle of a `ev_vsync` leaves pending set.
- R10: When an event arrives in the same cycle as a status read, the read returns the value before the event, and the flag is 1 afterwards.
- R11: A strobe at any address other than 0x28, or no strobe, returns 0 and clears no flag. Bits 31..28, 23..20, 18, 15..11, 9 and 7..3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_strobe | input | 1 | One-cycle register read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Status word when the read hits, else 0 |
| mod_enable | input | 1 | Module enabled level |
| ev_vsync | input | 1 | Frame sync pulse |
| fifo_flushing | input | 1 | FIFOs are being flushed |
| crc_fix_en | input | 1 | Sync-code correction enabled |
| crc_err | input | 1 | Uncorrected start/end code error pulse |
| prv_wr | input | 1 | Preview FIFO write attempt |
| prv_full | input | 1 | Preview FIFO full |
| cdc_wr | input | 1 | Codec FIFO write attempt |
| cdc_full | input | 1 | Codec FIFO full |
| prv_done | input | 1 | Preview DMA completion pulse |
| cdc_done | input | 1 | Codec DMA completion pulse |
| srst_done | input | 1 | Software reset completion pulse |
| dis_done | input | 1 | Disable completion pulse |
| chan_req | input | 1 | DMA channel status change request |
| chan_ack | output | 1 | Change request accepted |
| codec_req | input | 1 | Codec capture request |
| codec_fits | input | 1 | Request can be served in current frame |
| codec_go | output | 1 | Deferred codec request is issued |
| frame_skip | output | 1 | Current frame skipped (overrun) |
| frame_drop | output | 1 | Current frame dropped (CRC error) |

## Verification
Directed sequences apply each event with its qualifier both off and on: sync with and without flushing, CRC failure with and without correction, and writes to full and non-full FIFOs on each path. These show that a gated event raises its flag only when qualified and that the two paths stay separate. Further cases put a read in the same cycle as an event, send strobes to a wrong address, repeat change requests during the busy window, and issue a deferred codec request that crosses a frame sync. These separate clear-on-read from a lost event, and lockout from acceptance. A long run of random pulses, levels and reads then checks every read word and strobe output against a bench model built from the requirements.

// File: rtl/cam_stat_pkg.sv
package cam_stat_pkg;
   localparam int unsigned NUM_EV = 9;
   // Event slot order inside the sticky bank
   localparam int unsigned EV_OVR  = 0;
   localparam int unsigned EV_CRC  = 1;
   localparam int unsigned EV_COVF = 2;
   localparam int unsigned EV_POVF = 3;
   localparam int unsigned EV_CDN  = 4;
   localparam int unsigned EV_PDN  = 5;
   localparam int unsigned EV_VS   = 6;
   localparam int unsigned EV_SRST = 7;
   localparam int unsigned EV_DIS  = 8;
   // Status word bit each slot lands on (software decodes these)
   localparam int unsigned EV_POS [NUM_EV] = '{27, 26, 25, 24, 17, 16, 10, 2, 1};
   localparam int unsigned POS_BUSY = 19;
   localparam int unsigned POS_PEND = 8;
   localparam int unsigned POS_EN   = 0;
endpackage

// File: rtl/cam_evt_sticky.sv
module cam_evt_sticky #(
   parameter int unsigned N = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [N-1:0] ev,
   output logic [N-1:0] flag_q
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q[i] <= 1'b0;
         else        flag_q[i] <= (flag_q[i] & ~clr) | ev[i];
      end

      AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[i] && !clr) |=> flag_q[i]);               // R2
      AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
         (clr && !ev[i]) |=> !flag_q[i]);                  // R2
      AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         ev[i] |=> flag_q[i]);                             // R10
   end
endmodule

// File: rtl/cam_sync_busy.sv
module cam_sync_busy #(
   parameter int unsigned SYNC_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic ack,
   output logic busy
);
   if (SYNC_CYC == 0) begin : g_none
      assign busy = 1'b0;
      assign ack  = req;
   end else begin : g_timer
      localparam int unsigned CW = $clog2(SYNC_CYC + 1);
      localparam logic [CW-1:0] LOAD = CW'(SYNC_CYC);
      logic [CW-1:0] cnt_q;

      assign busy = (cnt_q != '0);
      assign ack  = req && !busy;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt_q <= '0;
         else if (ack)   cnt_q <= LOAD;
         else if (busy)  cnt_q <= cnt_q - 1'b1;
      end

      AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
         busy |-> !ack);                                   // R8
      AST_BUSY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
         ack |=> busy);                                    // R8
   end
endmodule

// File: rtl/cam_codec_pend.sv
module cam_codec_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic codec_req,
   input  logic codec_fits,
   input  logic frame_start,
   output logic pend,
   output logic go
);
   logic defer;
   assign defer = codec_req && !codec_fits;
   assign go    = pend && frame_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= defer | (pend & ~frame_start);
   end

   AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> $past(codec_req && !codec_fits));    // R9
   AST_PEND_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && frame_start && !defer) |=> !pend);          // R9
endmodule

// File: rtl/cam_status_reg.sv
module cam_status_reg
   import cam_stat_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned STAT_OFFSET = 'h28,
   parameter int unsigned SYNC_CYC    = 4,
   parameter int unsigned DATA_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_strobe,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   input  logic              mod_enable,
   input  logic              ev_vsync,
   input  logic              fifo_flushing,
   input  logic              crc_fix_en,
   input  logic              crc_err,
   input  logic              prv_wr,
   input  logic              prv_full,
   input  logic              cdc_wr,
   input  logic              cdc_full,
   input  logic              prv_done,
   input  logic              cdc_done,
   input  logic              srst_done,
   input  logic              dis_done,
   input  logic              chan_req,
   output logic              chan_ack,
   input  logic              codec_req,
   input  logic              codec_fits,
   output logic              codec_go,
   output logic              frame_skip,
   output logic              frame_drop
);
   if (DATA_W != 32) begin : g_bad_width
      $error("cam_status_reg: status word must be 32 bits");
   end
   if (ADDR_W < 6 || STAT_OFFSET >= (1 << ADDR_W)) begin : g_bad_addr
      $error("cam_status_reg: offset does not fit the address width");
   end

   logic              rd_hit;
   logic [NUM_EV-1:0] ev;
   logic [NUM_EV-1:0] flags;
   logic              busy, pend;
   logic [31:0]       word;

   assign rd_hit     = rd_strobe && (rd_addr == ADDR_W'(STAT_OFFSET));
   assign frame_skip = ev_vsync && fifo_flushing;
   assign frame_drop = crc_err && crc_fix_en;

   always_comb begin
      ev           = '0;
      ev[EV_OVR]   = frame_skip;
      ev[EV_CRC]   = frame_drop;
      ev[EV_COVF]  = cdc_wr && cdc_full;
      ev[EV_POVF]  = prv_wr && prv_full;
      ev[EV_CDN]   = cdc_done;
      ev[EV_PDN]   = prv_done;
      ev[EV_VS]    = ev_vsync;
      ev[EV_SRST]  = srst_done;
      ev[EV_DIS]   = dis_done;
   end

   cam_evt_sticky #(.N(NUM_EV)) u_sticky (
      .clk(clk), .rst_n(rst_n), .clr(rd_hit), .ev(ev), .flag_q(flags));

   cam_sync_busy #(.SYNC_CYC(SYNC_CYC)) u_busy (
      .clk(clk), .rst_n(rst_n), .req(chan_req), .ack(chan_ack), .busy(busy));

   cam_codec_pend u_pend (
      .clk(clk), .rst_n(rst_n), .codec_req(codec_req), .codec_fits(codec_fits),
      .frame_start(ev_vsync), .pend(pend), .go(codec_go));

   always_comb begin
      word = '0;
      for (int i = 0; i < NUM_EV; i++) word[EV_POS[i]] = flags[i];
      word[POS_BUSY] = busy;
      word[POS_PEND] = pend;
      word[POS_EN]   = mod_enable;
   end

   assign rd_data = rd_hit ? word : 32'h0;

   AST_OVR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word[27]) |-> $past(ev_vsync && fifo_flushing));     // R3
   AST_CRC_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word[26]) |-> $past(crc_err && crc_fix_en));         // R4
   AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |-> (rd_data == 32'h0));                           // R11
   AST_LIVE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |-> (rd_data[0] == mod_enable));                    // R7
endmodule

// File: tb/sim_cam_status_reg.sv
module sim_cam_status_reg;
   localparam int SYNC = 4;
   logic clk = 1'b0, rst_n = 1'b0;
   logic rd_strobe = 0; logic [7:0] rd_addr = 8'h28;
   logic [31:0] rd_data;
   logic mod_enable = 0, ev_vsync = 0, fifo_flushing = 0, crc_fix_en = 0, crc_err = 0;
   logic prv_wr = 0, prv_full = 0, cdc_wr = 0, cdc_full = 0, prv_done = 0, cdc_done = 0;
   logic srst_done = 0, dis_done = 0, chan_req = 0, codec_req = 0, codec_fits = 1;
   logic chan_ack, codec_go, frame_skip, frame_drop;
   int checks = 0, errors = 0;
   bit finished = 0;
   logic [31:0] m_stk = 0; int m_cnt = 0; bit m_pend = 0;

   always #2 clk = ~clk;

   cam_status_reg #(.ADDR_W(8), .STAT_OFFSET('h28), .SYNC_CYC(SYNC)) u0 (.*);

   function automatic logic [31:0] ev_word();
      logic [31:0] w = 0;
      w[27] = ev_vsync & fifo_flushing;  w[26] = crc_err & crc_fix_en;
      w[25] = cdc_wr & cdc_full;         w[24] = prv_wr & prv_full;
      w[17] = cdc_done; w[16] = prv_done; w[10] = ev_vsync;
      w[2] = srst_done; w[1] = dis_done;
      return w;
   endfunction

   function automatic logic [31:0] exp_word();
      logic [31:0] w = m_stk;
      w[19] = (m_cnt != 0); w[8] = m_pend; w[0] = mod_enable;
      return (rd_strobe && rd_addr == 8'h28) ? w : 32'h0;
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Check outputs against model, take one edge, advance model, clear pulses.
   task automatic step(string req);
      bit ack_e;
      #1;
      ack_e = chan_req && (m_cnt == 0);
      chk(req, "rd_data", rd_data, exp_word());
      chk(req, "chan_ack", {31'b0, chan_ack}, {31'b0, ack_e});
      chk(req, "codec_go", {31'b0, codec_go}, {31'b0, m_pend & ev_vsync});
      chk(req, "frame_skip", {31'b0, frame_skip}, {31'b0, ev_vsync & fifo_flushing});
      chk(req, "frame_drop", {31'b0, frame_drop}, {31'b0, crc_err & crc_fix_en});
      @(posedge clk);
      m_stk = ((rd_strobe && rd_addr == 8'h28) ? 32'h0 : m_stk) | ev_word();
      if (ack_e) m_cnt = SYNC; else if (m_cnt > 0) m_cnt--;
      m_pend = (codec_req & ~codec_fits) | (m_pend & ~ev_vsync);
      #1;
      {rd_strobe, ev_vsync, crc_err, prv_wr, cdc_wr, prv_done, cdc_done} = 0;
      {srst_done, dis_done, chan_req, codec_req} = 0;
      rd_addr = 8'h28;
   endtask

   task automatic rd(string req); rd_strobe = 1; step(req); endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      rd("R1");
      ev_vsync = 1; step("R6"); rd("R6"); rd("R2");
      ev_vsync = 1; fifo_flushing = 0; step("R3"); rd("R3");
      fifo_flushing = 1; ev_vsync = 1; step("R3"); rd("R3"); fifo_flushing = 0;
      crc_err = 1; step("R4"); rd("R4");
      crc_fix_en = 1; crc_err = 1; step("R4"); rd("R4");
      prv_wr = 1; cdc_wr = 1; step("R5"); rd("R5");
      prv_full = 1; prv_wr = 1; cdc_wr = 1; step("R5"); rd("R5");
      prv_full = 0; cdc_full = 1; cdc_wr = 1; step("R5"); rd("R5"); cdc_full = 0;
      prv_done = 1; cdc_done = 1; srst_done = 1; dis_done = 1; step("R6"); rd("R6");
      dis_done = 1; rd("R10"); rd("R10"); rd("R10");
      cdc_done = 1; step("R11"); rd_strobe = 1; rd_addr = 8'h2C; step("R11");
      rd("R11"); step("R11");
      mod_enable = 1; rd("R7"); rd("R7");
      chan_req = 1; step("R8");
      for (int k = 0; k < SYNC + 1; k++) begin chan_req = 1; rd_strobe = 1; step("R8"); end
      rd("R7");
      codec_fits = 0; codec_req = 1; step("R9"); rd("R9"); rd("R9");
      ev_vsync = 1; step("R9"); rd("R9");
      codec_req = 1; step("R9"); ev_vsync = 1; codec_req = 1; step("R9"); rd("R9");
      ev_vsync = 1; step("R9"); codec_fits = 1; rd("R2");
      void'($urandom(32'h5eed));
      for (int n = 0; n < 4000; n++) begin
         rd_strobe = ($urandom % 4) == 0;
         rd_addr = (($urandom % 8) == 0) ? 8'($urandom) : 8'h28;
         ev_vsync = ($urandom % 10) == 0; fifo_flushing = $urandom % 2;
         crc_fix_en = $urandom % 2; crc_err = ($urandom % 8) == 0;
         prv_full = $urandom % 2; cdc_full = $urandom % 2;
         prv_wr = ($urandom % 6) == 0; cdc_wr = ($urandom % 6) == 0;
         prv_done = ($urandom % 12) == 0; cdc_done = ($urandom % 12) == 0;
         srst_done = ($urandom % 16) == 0; dis_done = ($urandom % 16) == 0;
         chan_req = ($urandom % 3) == 0; codec_req = ($urandom % 8) == 0;
         codec_fits = $urandom % 2;
         if (($urandom % 50) == 0) mod_enable = ~mod_enable;
         step("R2");
      end
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule